// File: doc/BRIEF.md
# Removable Memory Card Bus Steering

This block sits between the host connector of a 16-bit removable memory card and two 8-bit memory segments, one holding the even-addressed bytes and one holding the odd-addressed bytes. It decodes the two active-low card enables and address bit 0 into one of four access shapes: word-wide across both data lanes, byte-wide on the low lane with even/odd segment choice, odd-byte-only on the high lane, or deselected. It then drives per-segment chip enables, read enables and one-cycle write strobes, and steers read and write data between the host lanes and the segments.

The host strobes are asynchronous to the card's internal clock. They pass through synchronisers, and their edges are detected on that clock. A write captures its target address when the write strobe falls and its data when the strobe rises, then issues exactly one segment write. A register-select input redirects accesses to a 2 KB attribute region. An active-high write-protect input blocks every segment write. When output enable and write enable are asserted together, the write is dropped and a sticky error flag is set.

Top module: `pc_card_bus_steer`

## Requirements
- R1: In byte mode (ce1_n=0, ce2_n=1) read data is driven only on host lane bits 7:0 (host_doe=2'b01), and write data is taken from host_din[7:0].
- R2: In byte mode address bit 0 = 0 targets the even segment (index 0, seg_wdata[7:0], seg_rdata[7:0]), and address bit 0 = 1 targets the odd segment (index 1, seg_wdata[15:8], seg_rdata[15:8]).
- R3: With ce1_n=0 and ce2_n=0 the access is word-wide: even segment on lane bits 7:0, odd segment on bits 15:8, host_doe=2'b11. Address bit 0 has no effect.
- R4: With both card enables high, or after reset, host_doe is 2'b00 and no segment read or write strobe is asserted.
- R5: With oe_n high, host_doe stays 2'b00. Data is driven only while oe_n is low and we_n is high.
- R6: A write uses the address present when we_n falls and the data present when we_n rises. Address changes while we_n is low, and data changes before the rise, have no effect.
- R7: With reg_n low, attr_sel is 1 and the segment address keeps only its low 10 bits (2 KB attribute region, byte address bits 10:0).
- R8: While wp is 1 no segment write strobe is issued.
- R9: wr_sector shows the captured write byte address shifted right by 8 (256-byte sectors).
- R10: With ce1_n=1 and ce2_n=0 the odd segment is accessed on lane bits 15:8 (host_doe=2'b10), and writes take host_din[15:8].
- R11: Each we_n low pulse produces exactly one seg_we pulse, one clock cycle long.
- R12: If oe_n is low during a we_n pulse, that write is suppressed and err_flag goes to 1 and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce1_n | input | 1 | Card enable, low lane (active low) |
| ce2_n | input | 1 | Card enable, high lane (active low) |
| oe_n | input | 1 | Output enable (active low) |
| we_n | input | 1 | Write enable (active low) |
| reg_n | input | 1 | Attribute region select (active low) |
| wp | input | 1 | Write protect (active high) |
| addr | input | ADDR_W | Host byte address |
| host_din | input | 16 | Data from the host bus |
| host_dout | output | 16 | Data toward the host bus |
| host_doe | output | 2 | Per-lane output enable; bit 0 covers bits 7:0 |
| seg_ce | output | 2 | Segment chip enables; bit 0 even, bit 1 odd |
| seg_re | output | 2 | Segment read enables |
| seg_we | output | 2 | Segment one-cycle write strobes |
| seg_addr | output | ADDR_W-1 | Byte-pair address to both segments |
| seg_wdata | output | 16 | Write data; 7:0 even, 15:8 odd |
| seg_rdata | input | 16 | Read data; 7:0 even, 15:8 odd |
| attr_sel | output | 1 | Access targets the attribute region |
| wr_sector | output | ADDR_W-8 | Sector index of the last captured write |
| err_flag | output | 1 | Sticky output/write enable conflict flag |

## Verification
The hardest case to reach from the ports is a write whose address and data change during the strobe. It needs the address to move after the captured falling edge and the data to settle only just before the rising edge. The bench drives a garbage value at the fall, changes both address and data several cycles into the low phase, and then reads back both the old and the new address. The overlap of output enable and write enable is reached by holding oe_n low across a complete write pulse. The bench then checks that no strobe appeared, that the flag stays set through a later legal write, and that the target location is still empty.

// File: rtl/pc_card_pkg.sv
package pc_card_pkg;
   typedef struct packed {
      logic [1:0] lane_en;
      logic [1:0] seg_sel;
      logic       lo_from_odd;
   } route_t;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
   parameter int W       = 1,
   parameter int STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   initial assert (STAGES >= 2) else $error("strobe_sync needs two stages");

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      stg[i] <= RST_VAL;
         else if (i == 0) stg[i] <= d;
         else             stg[i] <= stg[(i == 0) ? 0 : i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/lane_decode.sv
module lane_decode
   import pc_card_pkg::*;
(
   input  logic   ce1_n,
   input  logic   ce2_n,
   input  logic   a0,
   output route_t route
);
   always_comb begin
      route = '0;
      unique case ({ce1_n, ce2_n})
         2'b00: begin
            route.lane_en = 2'b11;
            route.seg_sel = 2'b11;
         end
         2'b01: begin
            route.lane_en     = 2'b01;
            route.seg_sel     = a0 ? 2'b10 : 2'b01;
            route.lo_from_odd = a0;
         end
         2'b10: begin
            route.lane_en = 2'b10;
            route.seg_sel = 2'b10;
         end
         default: route = '0;
      endcase
   end
endmodule

// File: rtl/write_capture.sv
module write_capture
   import pc_card_pkg::*;
#(
   parameter int ADDR_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_s,
   input  logic              oe_s,
   input  logic              wp_s,
   input  logic              reg_s,
   input  logic [ADDR_W-1:0] addr_q,
   input  route_t            route,
   input  logic [15:0]       host_din,
   output logic [1:0]        seg_we,
   output logic [ADDR_W-1:0] cap_addr,
   output logic              cap_attr,
   output logic [15:0]       wdata,
   output logic              err_flag
);
   logic       we_d;
   logic [1:0] cap_sel;
   logic       cap_lo_odd;
   logic       conflict;
   logic       fall_det, rise_det, blocked;

   assign fall_det = we_d && !we_s;
   assign rise_det = !we_d && we_s;
   assign blocked  = conflict || !oe_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_d       <= 1'b1;
         cap_sel    <= '0;
         cap_lo_odd <= 1'b0;
         cap_addr   <= '0;
         cap_attr   <= 1'b0;
         conflict   <= 1'b0;
         wdata      <= '0;
         seg_we     <= '0;
         err_flag   <= 1'b0;
      end else begin
         we_d   <= we_s;
         seg_we <= '0;
         if (fall_det) begin
            cap_addr   <= addr_q;
            cap_sel    <= route.seg_sel;
            cap_lo_odd <= route.lo_from_odd;
            cap_attr   <= !reg_s;
            conflict   <= !oe_s;
         end else if (!we_s && !oe_s) begin
            conflict <= 1'b1;
         end
         if (rise_det) begin
            wdata[7:0]  <= host_din[7:0];
            wdata[15:8] <= cap_lo_odd ? host_din[7:0] : host_din[15:8];
            if (blocked)    err_flag <= 1'b1;
            else if (!wp_s) seg_we   <= cap_sel;
         end
      end
   end

   // R11: a strobe lasts a single cycle
   assert_we_single_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_we != 2'b00) |=> (seg_we == 2'b00));
   // R12: the conflict flag never clears outside reset
   assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag);
   // R8: no strobe follows a cycle with protection active
   assert_wp_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_we != 2'b00) |-> !$past(wp_s));
endmodule

// File: rtl/pc_card_bus_steer.sv
module pc_card_bus_steer
   import pc_card_pkg::*;
#(
   parameter int ADDR_W       = 18,
   parameter int ATTR_BYTES   = 2048,
   parameter int SECTOR_BYTES = 256,
   parameter int SYNC_STAGES  = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ce1_n,
   input  logic                  ce2_n,
   input  logic                  oe_n,
   input  logic                  we_n,
   input  logic                  reg_n,
   input  logic                  wp,
   input  logic [ADDR_W-1:0]     addr,
   input  logic [15:0]           host_din,
   output logic [15:0]           host_dout,
   output logic [1:0]            host_doe,
   output logic [1:0]            seg_ce,
   output logic [1:0]            seg_re,
   output logic [1:0]            seg_we,
   output logic [ADDR_W-2:0]     seg_addr,
   output logic [15:0]           seg_wdata,
   input  logic [15:0]           seg_rdata,
   output logic                  attr_sel,
   output logic [ADDR_W-$clog2(SECTOR_BYTES)-1:0] wr_sector,
   output logic                  err_flag
);
   localparam int SEG_AW  = ADDR_W - 1;
   localparam int ATTR_AW = $clog2(ATTR_BYTES);
   localparam int SECT_SH = $clog2(SECTOR_BYTES);
   localparam logic [SEG_AW-1:0] ATTR_MASK = SEG_AW'((1 << (ATTR_AW - 1)) - 1);

   initial assert (ADDR_W > SECT_SH && ATTR_AW <= ADDR_W && ATTR_AW >= 2)
      else $error("pc_card_bus_steer: inconsistent address parameters");

   logic [5:0]        raw_ctl, sync_ctl;
   logic              ce1_s, ce2_s, oe_s, we_s, reg_s, wp_s;
   logic [ADDR_W-1:0] addr_q, cap_addr;
   logic              cap_attr, rd_act, wr_act, use_attr;
   logic [SEG_AW-1:0] base_addr;
   route_t            route;

   assign raw_ctl = {ce1_n, ce2_n, oe_n, we_n, reg_n, wp};

   strobe_sync #(.W(6), .STAGES(SYNC_STAGES), .RST_VAL(6'b111110)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_ctl), .q(sync_ctl));

   assign {ce1_s, ce2_s, oe_s, we_s, reg_s, wp_s} = sync_ctl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) addr_q <= '0;
      else        addr_q <= addr;
   end

   lane_decode u_dec (.ce1_n(ce1_s), .ce2_n(ce2_s), .a0(addr_q[0]), .route(route));

   write_capture #(.ADDR_W(ADDR_W)) u_wr (
      .clk(clk), .rst_n(rst_n), .we_s(we_s), .oe_s(oe_s), .wp_s(wp_s),
      .reg_s(reg_s), .addr_q(addr_q), .route(route), .host_din(host_din),
      .seg_we(seg_we), .cap_addr(cap_addr), .cap_attr(cap_attr),
      .wdata(seg_wdata), .err_flag(err_flag));

   assign wr_act   = seg_we != 2'b00;
   assign rd_act   = !oe_s && we_s;
   assign seg_re   = rd_act ? route.seg_sel : 2'b00;
   assign host_doe = rd_act ? route.lane_en : 2'b00;
   assign seg_ce   = seg_re | seg_we;

   assign use_attr  = wr_act ? cap_attr : !reg_s;
   assign base_addr = wr_act ? cap_addr[ADDR_W-1:1] : addr_q[ADDR_W-1:1];
   assign seg_addr  = use_attr ? (base_addr & ATTR_MASK) : base_addr;
   assign attr_sel  = use_attr;
   assign wr_sector = cap_addr[ADDR_W-1:SECT_SH];

   assign host_dout[7:0]  = route.lo_from_odd ? seg_rdata[15:8] : seg_rdata[7:0];
   assign host_dout[15:8] = seg_rdata[15:8];

   // R4: deselected card drives nothing
   assert_deselect_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ce1_s && ce2_s) |-> (host_doe == 2'b00 && seg_re == 2'b00));
   // R5: bus floats while output enable is inactive
   assert_oe_gates_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
      oe_s |-> (host_doe == 2'b00));
endmodule

// File: tb/pc_card_bus_steer_tb.sv
module pc_card_bus_steer_tb;
   localparam int ADDR_W = 18;

   typedef struct packed {
      logic              reg_n;
      logic              ce1_n;
      logic              ce2_n;
      logic [ADDR_W-1:0] addr;
      logic [1:0]        doe;
      logic [15:0]       dout;
   } rd_vec_t;

   // reads walked after the preload writes
   localparam rd_vec_t VEC [0:9] = '{
      '{1'b1, 1'b0, 1'b0, 18'h00020, 2'b11, 16'hB2A1},  // R3 word
      '{1'b1, 1'b0, 1'b0, 18'h00021, 2'b11, 16'hB2A1},  // R3 a0 ignored
      '{1'b1, 1'b0, 1'b1, 18'h00040, 2'b01, 16'h0054},  // R1 R2 even
      '{1'b1, 1'b0, 1'b1, 18'h00041, 2'b01, 16'h00C3},  // R1 R2 odd
      '{1'b1, 1'b0, 1'b1, 18'h00021, 2'b01, 16'h00B2},  // R2 odd on low lane
      '{1'b1, 1'b1, 1'b0, 18'h00061, 2'b10, 16'hE700},  // R10 odd high lane
      '{1'b1, 1'b1, 1'b1, 18'h00020, 2'b00, 16'h0000},  // R4 deselected
      '{1'b1, 1'b0, 1'b0, 18'h00040, 2'b11, 16'hC354},  // R3 byte writes merge
      '{1'b0, 1'b0, 1'b0, 18'h00020, 2'b11, 16'h9988},  // R7 attribute
      '{1'b0, 1'b0, 1'b0, 18'h3F820, 2'b11, 16'h9988}   // R7 alias in 2 KB
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic ce1_n = 1'b1, ce2_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, reg_n = 1'b1, wp = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [15:0] host_din = '0, host_dout, seg_wdata, seg_rdata;
   logic [1:0]  host_doe, seg_ce, seg_re, seg_we;
   logic [ADDR_W-2:0] seg_addr;
   logic        attr_sel, err_flag;
   logic [ADDR_W-9:0] wr_sector;

   int checks = 0, fails = 0, pulses = 0, wide_pulses = 0;
   bit finished = 0;
   logic [1:0] prev_we = '0;

   logic [7:0] cm [2][1024];
   logic [7:0] am [2][1024];

   always #5 clk = ~clk;

   pc_card_bus_steer u_dut (
      .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2_n(ce2_n), .oe_n(oe_n),
      .we_n(we_n), .reg_n(reg_n), .wp(wp), .addr(addr), .host_din(host_din),
      .host_dout(host_dout), .host_doe(host_doe), .seg_ce(seg_ce),
      .seg_re(seg_re), .seg_we(seg_we), .seg_addr(seg_addr),
      .seg_wdata(seg_wdata), .seg_rdata(seg_rdata), .attr_sel(attr_sel),
      .wr_sector(wr_sector), .err_flag(err_flag));

   initial begin
      for (int s = 0; s < 2; s++)
         for (int i = 0; i < 1024; i++) begin
            cm[s][i] = 8'h00;
            am[s][i] = 8'h00;
         end
   end

   // segment memory models
   always @(posedge clk) begin
      for (int s = 0; s < 2; s++) begin
         if (seg_we[s]) begin
            if (attr_sel) am[s][seg_addr[9:0]] <= seg_wdata[s*8 +: 8];
            else          cm[s][seg_addr[9:0]] <= seg_wdata[s*8 +: 8];
         end
         seg_rdata[s*8 +: 8] <= attr_sel ? am[s][seg_addr[9:0]] : cm[s][seg_addr[9:0]];
      end
      if (seg_we != 2'b00) pulses <= pulses + 1;
      if (seg_we != 2'b00 && prev_we != 2'b00) wide_pulses <= wide_pulses + 1;
      prev_we <= seg_we;
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic do_write(input logic r, input logic c1, input logic c2,
                           input logic [ADDR_W-1:0] a, input logic [15:0] d);
      reg_n = r; ce1_n = c1; ce2_n = c2; addr = a; host_din = 16'hFFFF;
      cyc(4);
      we_n = 1'b0;
      cyc(4);
      host_din = d;
      cyc(4);
      we_n = 1'b1;
      cyc(8);
      ce1_n = 1'b1; ce2_n = 1'b1; reg_n = 1'b1;
      cyc(4);
   endtask

   task automatic do_read(input logic r, input logic c1, input logic c2,
                          input logic [ADDR_W-1:0] a);
      reg_n = r; ce1_n = c1; ce2_n = c2; addr = a;
      cyc(2);
      oe_n = 1'b0;
      cyc(6);
      @(negedge clk);
   endtask

   task automatic end_read;
      oe_n = 1'b1; ce1_n = 1'b1; ce2_n = 1'b1; reg_n = 1'b1;
      cyc(4);
   endtask

   function automatic logic [15:0] lane_mask(input logic [1:0] en);
      return {{8{en[1]}}, {8{en[0]}}};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int p0;
      cyc(3);
      @(negedge clk);
      // R4 reset state
      check(host_doe == 2'b00 && seg_ce == 2'b00 && err_flag == 1'b0, "R4 reset",
            {host_doe, seg_ce, 3'b0, err_flag}, 0);
      rst_n = 1'b1;
      cyc(4);

      do_write(1'b1, 1'b0, 1'b0, 18'h00020, 16'hB2A1);
      do_write(1'b1, 1'b0, 1'b1, 18'h00041, 16'h00C3);
      do_write(1'b1, 1'b0, 1'b1, 18'h00040, 16'h0054);
      do_write(1'b1, 1'b1, 1'b0, 18'h00061, 16'hE700);
      do_write(1'b0, 1'b0, 1'b0, 18'h00020, 16'h9988);
      check(pulses == 5, "R11 one strobe per write", pulses, 5);

      for (int i = 0; i < 10; i++) begin
         do_read(VEC[i].reg_n, VEC[i].ce1_n, VEC[i].ce2_n, VEC[i].addr);
         check(host_doe == VEC[i].doe, "R1 R3 R4 R10 lane enable", host_doe, VEC[i].doe);
         check((host_dout & lane_mask(VEC[i].doe)) == VEC[i].dout, "R2 R3 R7 R10 read data",
               host_dout & lane_mask(VEC[i].doe), VEC[i].dout);
         if (i == 9) begin
            check(attr_sel == 1'b1 && seg_addr == 17'h00010, "R7 attribute address",
                  {attr_sel, seg_addr}, {1'b1, 17'h00010});
         end
         end_read();
      end

      // R5 output enable high leaves bus floating
      reg_n = 1'b1; ce1_n = 1'b0; ce2_n = 1'b0; addr = 18'h20;
      cyc(6);
      @(negedge clk);
      check(host_doe == 2'b00, "R5 oe high", host_doe, 0);
      end_read();

      // R6 address from falling edge, data from rising edge
      reg_n = 1'b1; ce1_n = 1'b0; ce2_n = 1'b0; addr = 18'h00080; host_din = 16'hFFFF;
      cyc(4);
      we_n = 1'b0;
      cyc(6);
      addr = 18'h00090;
      cyc(3);
      host_din = 16'h1234;
      cyc(4);
      we_n = 1'b1;
      cyc(8);
      ce1_n = 1'b1; ce2_n = 1'b1;
      cyc(4);
      do_read(1'b1, 1'b0, 1'b0, 18'h00080);
      check(host_dout == 16'h1234, "R6 captured address and data", host_dout, 16'h1234);
      end_read();
      do_read(1'b1, 1'b0, 1'b0, 18'h00090);
      check(host_dout == 16'h0000, "R6 late address ignored", host_dout, 0);
      end_read();

      // R8 write protect
      p0 = pulses;
      wp = 1'b1;
      do_write(1'b1, 1'b0, 1'b0, 18'h000A0, 16'h5555);
      wp = 1'b0;
      cyc(4);
      check(pulses == p0, "R8 no strobe when protected", pulses, p0);
      do_read(1'b1, 1'b0, 1'b0, 18'h000A0);
      check(host_dout == 16'h0000, "R8 protected location unchanged", host_dout, 0);
      end_read();

      // R9 sector index
      do_write(1'b1, 1'b0, 1'b0, 18'h34567, 16'hA5A5);
      check(wr_sector == 10'h345, "R9 sector index", wr_sector, 10'h345);

      // R12 oe and we overlap
      p0 = pulses;
      oe_n = 1'b0;
      do_write(1'b1, 1'b0, 1'b0, 18'h000B0, 16'h7777);
      oe_n = 1'b1;
      cyc(4);
      check(pulses == p0, "R12 overlapped write suppressed", pulses, p0);
      check(err_flag == 1'b1, "R12 error flag set", err_flag, 1);
      do_write(1'b1, 1'b0, 1'b0, 18'h000C0, 16'h1111);
      check(err_flag == 1'b1, "R12 error flag sticky", err_flag, 1);
      check(pulses == p0 + 1, "R11 legal write after conflict", pulses, p0 + 1);
      do_read(1'b1, 1'b0, 1'b0, 18'h000B0);
      check(host_dout == 16'h0000, "R12 target untouched", host_dout, 0);
      end_read();

      check(wide_pulses == 0, "R11 strobe width", wide_pulses, 0);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule